// File: doc/BRIEF.md
# Register-Pair ALU with Flag Register

This block performs the register-to-register arithmetic and logic group of a small 8-bit interpreter-style processor, together with the immediate load and immediate add. The surrounding pipeline reads the two operand registers, Vx and Vy, from its sixteen-entry byte register file. It presents the opcode and both operand values with a one-cycle `start` strobe. One cycle later the block returns a done pulse, a result byte with a write enable aimed at Vx, and a flag byte with a write enable aimed at register 15, which serves as the carry, borrow or shifted-out-bit flag.

The block holds no register state of its own. The result is written back to the register selected by opcode bits [11:8]. When that register is the flag register and the operation also produces a flag, only the flag write is issued. Opcodes that this group does not define produce no write and raise an illegal-operation pulse alongside done.

Top module: `regpair_alu`

## Requirements
- R1: Reset clears every output to 0. `done` is high exactly in the cycle after a cycle with `start` high. No write enable and no `illegal` pulse is ever high without `done`.
- R2: Class 8 (opcode bits [15:12] = 8) selects the operation with sub-op bits [3:0]. Sub-op 0 returns Vy, 1 returns Vx OR Vy, 2 returns Vx AND Vy, and 3 returns Vx XOR Vy. Each asserts `res_we` and leaves `flag_we` low.
- R3: Sub-op 4 returns the low 8 bits of Vx+Vy. The flag is 1 exactly when the 9-bit sum exceeds 255.
- R4: Sub-op 5 returns Vx−Vy modulo 256. The flag is 1 exactly when Vx > Vy, so equal operands give 0.
- R5: Sub-op 7 returns Vy−Vx modulo 256. The flag is 1 exactly when Vy > Vx.
- R6: Sub-op 6 places bit 0 of Vx in the flag and returns Vx shifted right by one, with bit 7 of the result set to 0.
- R7: Sub-op E places bit 7 of Vx in the flag and returns Vx shifted left by one, keeping 8 bits, with bit 0 of the result set to 0.
- R8: Class 6 returns the immediate in opcode bits [7:0]. Class 7 returns Vx plus that immediate modulo 256. Neither raises `flag_we`.
- R9: When opcode bits [11:8] equal 15 and the operation writes the flag, `res_we` stays low and `flag_we` is high. Operations that do not write the flag still write their result when x is 15.
- R10: Class 8 with sub-op 8 to D or F, or any class other than 6, 7 or 8, gives `illegal` high with `done` and leaves both write enables low.
- R11: `flag_data` is always 0 or 1. `res_data` is 0 whenever `res_we` is low, and `flag_data` is 0 whenever `flag_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, one cycle per operation |
| opcode | input | 16 | Instruction word: class [15:12], x [11:8], immediate [7:0], sub-op [3:0] |
| vx_val | input | 8 | Current value of register x |
| vy_val | input | 8 | Current value of register y |
| res_data | output | 8 | Value to write into register x |
| res_we | output | 1 | Write enable for register x |
| flag_data | output | 8 | Value to write into the flag register (0 or 1) |
| flag_we | output | 1 | Write enable for the flag register |
| done | output | 1 | Operation complete, one cycle after start |
| illegal | output | 1 | Opcode outside this group, pulses with done |

## Verification
The assertions assume that `opcode`, `vx_val` and `vy_val` carry known values at every clock edge after reset, including cycles without `start`. This is because the arithmetic checks on the shifter and the subtractor look at the datapath on every cycle. The bench holds all inputs at defined values from time zero and changes them only on falling edges. It drives `start` either as an isolated pulse or on two consecutive cycles, so the one-cycle done relation is exercised both ways. The `illegal` case and the write enables are always observed together with `done`.

// File: rtl/regpair_alu_pkg.sv
package regpair_alu_pkg;

   localparam int CLS_W = 4;
   localparam int SUB_W = 4;

   localparam logic [CLS_W-1:0] CLS_LOAD_IMM = 4'h6;
   localparam logic [CLS_W-1:0] CLS_ADD_IMM  = 4'h7;
   localparam logic [CLS_W-1:0] CLS_PAIR     = 4'h8;

   localparam logic [SUB_W-1:0] SUB_MOVE  = 4'h0;
   localparam logic [SUB_W-1:0] SUB_OR    = 4'h1;
   localparam logic [SUB_W-1:0] SUB_AND   = 4'h2;
   localparam logic [SUB_W-1:0] SUB_XOR   = 4'h3;
   localparam logic [SUB_W-1:0] SUB_ADD   = 4'h4;
   localparam logic [SUB_W-1:0] SUB_XMY   = 4'h5;
   localparam logic [SUB_W-1:0] SUB_SHR   = 4'h6;
   localparam logic [SUB_W-1:0] SUB_YMX   = 4'h7;
   localparam logic [SUB_W-1:0] SUB_SHL   = 4'hE;

   typedef enum logic [3:0] {
      K_MOVE,
      K_OR,
      K_AND,
      K_XOR,
      K_ADD,
      K_XMY,
      K_SHR,
      K_YMX,
      K_SHL,
      K_LDI,
      K_ADI,
      K_BAD
   } alu_kind_e;

endpackage

// File: rtl/regpair_alu_decode.sv
module regpair_alu_decode
   import regpair_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_IDX_W = 4,
   localparam int OPC_W    = CLS_W + REG_IDX_W + DATA_W
)(
   input  logic [OPC_W-1:0]     opcode,
   output alu_kind_e            kind,
   output logic [REG_IDX_W-1:0] x_idx,
   output logic [DATA_W-1:0]    imm
);

   logic [CLS_W-1:0] cls;
   logic [SUB_W-1:0] sub;

   generate
      if (DATA_W < REG_IDX_W + SUB_W) begin : g_bad_width
         $error("regpair_alu_decode: DATA_W must hold the y field and the sub-op");
      end
   endgenerate

   assign cls   = opcode[OPC_W-1 -: CLS_W];
   assign x_idx = opcode[DATA_W +: REG_IDX_W];
   assign imm   = opcode[DATA_W-1:0];
   assign sub   = imm[SUB_W-1:0];

   always_comb begin
      kind = K_BAD;
      if (cls == CLS_LOAD_IMM) begin
         kind = K_LDI;
      end else if (cls == CLS_ADD_IMM) begin
         kind = K_ADI;
      end else if (cls == CLS_PAIR) begin
         case (sub)
            SUB_MOVE: kind = K_MOVE;
            SUB_OR:   kind = K_OR;
            SUB_AND:  kind = K_AND;
            SUB_XOR:  kind = K_XOR;
            SUB_ADD:  kind = K_ADD;
            SUB_XMY:  kind = K_XMY;
            SUB_SHR:  kind = K_SHR;
            SUB_YMX:  kind = K_YMX;
            SUB_SHL:  kind = K_SHL;
            default:  kind = K_BAD;
         endcase
      end
   end

endmodule

// File: rtl/regpair_alu_core.sv
module regpair_alu_core
   import regpair_alu_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  alu_kind_e         kind,
   input  logic [DATA_W-1:0] vx,
   input  logic [DATA_W-1:0] vy,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] res,
   output logic              flag_bit,
   output logic              wr_res,
   output logic              wr_flag,
   output logic              bad_op
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   sum_xy;
   logic [DATA_W-1:0] sum_xi;
   logic [DATA_W-1:0] dif_xy;
   logic [DATA_W-1:0] dif_yx;
   logic              x_gt_y;
   logic              y_gt_x;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("regpair_alu_core: DATA_W must be at least 2");
      end
   endgenerate

   assign sum_xy = {1'b0, vx} + {1'b0, vy};
   assign sum_xi = vx + imm;
   assign dif_xy = vx - vy;
   assign dif_yx = vy - vx;
   assign x_gt_y = (vx > vy);
   assign y_gt_x = (vy > vx);

   always_comb begin
      res      = '0;
      flag_bit = 1'b0;
      wr_res   = 1'b0;
      wr_flag  = 1'b0;
      bad_op   = 1'b0;
      case (kind)
         K_MOVE: begin res = vy;      wr_res = 1'b1; end
         K_OR:   begin res = vx | vy; wr_res = 1'b1; end
         K_AND:  begin res = vx & vy; wr_res = 1'b1; end
         K_XOR:  begin res = vx ^ vy; wr_res = 1'b1; end
         K_ADD: begin
            res = sum_xy[MSB:0]; flag_bit = sum_xy[DATA_W];
            wr_res = 1'b1; wr_flag = 1'b1;
         end
         K_XMY: begin
            res = dif_xy; flag_bit = x_gt_y;
            wr_res = 1'b1; wr_flag = 1'b1;
         end
         K_YMX: begin
            res = dif_yx; flag_bit = y_gt_x;
            wr_res = 1'b1; wr_flag = 1'b1;
         end
         K_SHR: begin
            res = {1'b0, vx[MSB:1]}; flag_bit = vx[0];
            wr_res = 1'b1; wr_flag = 1'b1;
         end
         K_SHL: begin
            res = {vx[MSB-1:0], 1'b0}; flag_bit = vx[MSB];
            wr_res = 1'b1; wr_flag = 1'b1;
         end
         K_LDI:  begin res = imm;    wr_res = 1'b1; end
         K_ADI:  begin res = sum_xi; wr_res = 1'b1; end
         default: bad_op = 1'b1;
      endcase
   end

   // R6
   shr_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_SHR) |-> !res[MSB]);

   // R7
   shl_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_SHL) |-> !res[0]);

   // R4
   xmy_borrow_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XMY && flag_bit) |-> (res != '0));

   // R5
   ymx_equal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_YMX && vx == vy) |-> (!flag_bit && res == '0));

endmodule

// File: rtl/regpair_alu_wb.sv
module regpair_alu_wb #(
   parameter int DATA_W    = 8,
   parameter int REG_IDX_W = 4,
   parameter int FLAG_IDX  = 15,
   parameter bit OUT_REG   = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [REG_IDX_W-1:0] x_idx,
   input  logic [DATA_W-1:0]    res,
   input  logic                 flag_bit,
   input  logic                 wr_res,
   input  logic                 wr_flag,
   input  logic                 bad_op,
   output logic [DATA_W-1:0]    res_data_o,
   output logic                 res_we_o,
   output logic [DATA_W-1:0]    flag_data_o,
   output logic                 flag_we_o,
   output logic                 done_o,
   output logic                 illegal_o
);

   localparam logic [REG_IDX_W-1:0] FLAG_SEL = FLAG_IDX[REG_IDX_W-1:0];

   logic              flag_hit;
   logic              n_rwe;
   logic              n_fwe;
   logic              n_ill;
   logic [DATA_W-1:0] n_res;
   logic [DATA_W-1:0] n_flag;

   assign flag_hit = wr_flag && (x_idx == FLAG_SEL);
   assign n_rwe    = start && wr_res && !flag_hit;
   assign n_fwe    = start && wr_flag;
   assign n_ill    = start && bad_op;
   assign n_res    = n_rwe ? res : '0;
   assign n_flag   = n_fwe ? {{(DATA_W-1){1'b0}}, flag_bit} : '0;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_data_o  <= '0;
               res_we_o    <= 1'b0;
               flag_data_o <= '0;
               flag_we_o   <= 1'b0;
               done_o      <= 1'b0;
               illegal_o   <= 1'b0;
            end else begin
               res_data_o  <= n_res;
               res_we_o    <= n_rwe;
               flag_data_o <= n_flag;
               flag_we_o   <= n_fwe;
               done_o      <= start;
               illegal_o   <= n_ill;
            end
         end

         // R1
         done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> done_o);

         // R1
         done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !start |=> !done_o);
      end else begin : g_comb
         assign res_data_o  = n_res;
         assign res_we_o    = n_rwe;
         assign flag_data_o = n_flag;
         assign flag_we_o   = n_fwe;
         assign done_o      = start;
         assign illegal_o   = n_ill;
      end
   endgenerate

   // R10
   illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!res_we_o && !flag_we_o));

   // R1
   pulse_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we_o || flag_we_o || illegal_o) |-> done_o);

   // R11
   flag_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_data_o[DATA_W-1:1] == '0);

   // R11
   idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_we_o |-> res_data_o == '0) and (!flag_we_o |-> flag_data_o == '0));

endmodule

// File: rtl/regpair_alu.sv
module regpair_alu
   import regpair_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_IDX_W = 4,
   parameter int FLAG_IDX  = 15,
   parameter bit OUT_REG   = 1'b1,
   localparam int OPC_W    = CLS_W + REG_IDX_W + DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] vx_val,
   input  logic [DATA_W-1:0] vy_val,
   output logic [DATA_W-1:0] res_data,
   output logic              res_we,
   output logic [DATA_W-1:0] flag_data,
   output logic              flag_we,
   output logic              done,
   output logic              illegal
);

   alu_kind_e            kind;
   logic [REG_IDX_W-1:0] x_idx;
   logic [DATA_W-1:0]    imm;
   logic [DATA_W-1:0]    core_res;
   logic                 core_flag;
   logic                 core_wr_res;
   logic                 core_wr_flag;
   logic                 core_bad;

   generate
      if (FLAG_IDX < 0 || FLAG_IDX >= (1 << REG_IDX_W)) begin : g_bad_flag
         $error("regpair_alu: FLAG_IDX lies outside the register index range");
      end
   endgenerate

   regpair_alu_decode #(
      .DATA_W    (DATA_W),
      .REG_IDX_W (REG_IDX_W)
   ) u_decode (
      .opcode (opcode),
      .kind   (kind),
      .x_idx  (x_idx),
      .imm    (imm)
   );

   regpair_alu_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .vx       (vx_val),
      .vy       (vy_val),
      .imm      (imm),
      .res      (core_res),
      .flag_bit (core_flag),
      .wr_res   (core_wr_res),
      .wr_flag  (core_wr_flag),
      .bad_op   (core_bad)
   );

   regpair_alu_wb #(
      .DATA_W    (DATA_W),
      .REG_IDX_W (REG_IDX_W),
      .FLAG_IDX  (FLAG_IDX),
      .OUT_REG   (OUT_REG)
   ) u_wb (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .x_idx       (x_idx),
      .res         (core_res),
      .flag_bit    (core_flag),
      .wr_res      (core_wr_res),
      .wr_flag     (core_wr_flag),
      .bad_op      (core_bad),
      .res_data_o  (res_data),
      .res_we_o    (res_we),
      .flag_data_o (flag_data),
      .flag_we_o   (flag_we),
      .done_o      (done),
      .illegal_o   (illegal)
   );

endmodule

// File: tb/regpair_alu_tb.sv
module regpair_alu_tb;

   localparam int NV = 28;
   localparam int AW = 20;

   // fields: tag[47:44] opcode[43:28] vx[27:20] vy[19:12] res[11:4] rwe[3] flag[2] fwe[1] ill[0]
   localparam logic [47:0] VEC [NV] = '{
      {4'd2,  16'h8120, 8'h12, 8'h34, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 move
      {4'd2,  16'h8121, 8'h0F, 8'hF0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 or
      {4'd2,  16'h8122, 8'h3C, 8'h0F, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 and
      {4'd2,  16'h8123, 8'hAA, 8'hFF, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 xor
      {4'd3,  16'h8124, 8'h80, 8'h7F, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 no carry
      {4'd3,  16'h8124, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 carry
      {4'd3,  16'h8124, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 carry edge
      {4'd4,  16'h8125, 8'h10, 8'h05, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 x>y
      {4'd4,  16'h8125, 8'h05, 8'h05, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 equal
      {4'd4,  16'h8125, 8'h05, 8'h10, 8'hF5, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 wrap
      {4'd5,  16'h8127, 8'h05, 8'h10, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 y>x
      {4'd5,  16'h8127, 8'h10, 8'h05, 8'hF5, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 wrap
      {4'd5,  16'h8127, 8'h33, 8'h33, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 equal
      {4'd6,  16'h8126, 8'h81, 8'h00, 8'h40, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 odd
      {4'd6,  16'h8126, 8'h02, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 even
      {4'd7,  16'h812E, 8'h81, 8'h00, 8'h02, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 top set
      {4'd7,  16'h812E, 8'h40, 8'hFF, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 top clear
      {4'd8,  16'h6A5C, 8'h99, 8'h11, 8'h5C, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 load imm
      {4'd8,  16'h7AF0, 8'h20, 8'h11, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 add imm wrap
      {4'd8,  16'h7A01, 8'hFF, 8'h11, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 no flag on wrap
      {4'd9,  16'h8F24, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 flag wins
      {4'd9,  16'h8F20, 8'h00, 8'h77, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 move into x=15
      {4'd9,  16'h8F26, 8'h03, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 shift x=15
      {4'd9,  16'h6F07, 8'h00, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 load x=15
      {4'd10, 16'h8128, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 sub-op 8
      {4'd10, 16'h812F, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 sub-op F
      {4'd10, 16'h9120, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 class 9
      {4'd10, 16'h0123, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}  // R10 class 0
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] opcode = 16'h0000;
   logic [7:0]  vx_val = 8'h00;
   logic [7:0]  vy_val = 8'h00;
   logic [7:0]  res_data;
   logic        res_we;
   logic [7:0]  flag_data;
   logic        flag_we;
   logic        done;
   logic        illegal;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   regpair_alu u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .vx_val    (vx_val),
      .vy_val    (vy_val),
      .res_data  (res_data),
      .res_we    (res_we),
      .flag_data (flag_data),
      .flag_we   (flag_we),
      .done      (done),
      .illegal   (illegal)
   );

   function automatic logic [AW-1:0] outs();
      return {done, res_data, res_we, flag_data, flag_we, illegal};
   endfunction

   function automatic logic [AW-1:0] expect_of(logic dn, logic [7:0] r, logic rwe,
                                                logic f, logic fwe, logic ill);
      return {dn, r, rwe, 7'b0, f, fwe, ill};
   endfunction

   task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%05h exp=%05h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset", outs(), '0);
      rst_n = 1'b1;

      // R1 idle: inputs move without start
      @(negedge clk);
      opcode = 16'h8124; vx_val = 8'hFF; vy_val = 8'hFF;
      @(negedge clk);
      check("R1 idle", outs(), '0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         logic [47:0] v;
         v = VEC[k];
         @(negedge clk);
         start = 1'b1; opcode = v[43:28]; vx_val = v[27:20]; vy_val = v[19:12];
         @(negedge clk);
         start = 1'b0;
         check($sformatf("R%0d vec%0d", v[47:44], k), outs(),
               expect_of(1'b1, v[11:4], v[3], v[2], v[1], v[0]));
      end

      // R1 done drops after a single pulse
      @(negedge clk);
      check("R1 done falls", outs(), '0);

      // R1 back-to-back starts: add then subtract
      start = 1'b1; opcode = 16'h8124; vx_val = 8'h01; vy_val = 8'h02;
      @(negedge clk);
      check("R1 b2b first R3", outs(), expect_of(1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0));
      opcode = 16'h8125;
      @(negedge clk);
      start = 1'b0;
      check("R1 b2b second R4", outs(), expect_of(1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0));
      @(negedge clk);
      check("R1 b2b end", outs(), '0);

      // R11 flag-only write keeps result data at zero while x is 15
      start = 1'b1; opcode = 16'h8F2E; vx_val = 8'hFF; vy_val = 8'h00;
      @(negedge clk);
      start = 1'b0;
      check("R11 R9 shl x15", outs(), expect_of(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0));

      // R1 reset in the middle of a result
      @(negedge clk);
      start = 1'b1; opcode = 16'h6123;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 async reset", outs(), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", outs(), '0);

      finish_run();
   end

endmodule